// File: doc/BRIEF.md
# Triggered Frame Readout Sequencer

This block runs the timing for one sensor frame capture each time a hardware trigger arrives. While idle it only watches the trigger input. When it accepts a trigger it captures the exposure length and the row geometry, and it raises a frame request. It then steps through a row-reset phase of fixed length, an exposure wait of programmable length, and a readout in which each row is framed by line-valid. A pace strobe marks the start of every row, and frame-valid covers the whole readout. A one-cycle done pulse closes the frame, and the machine goes back to idle.

Any trigger that arrives while a frame is in progress has no effect on the timing. Each such trigger adds one to a saturating overrun count. The block has no data path. Every pin is a plain level or a single-cycle strobe, so there is no valid/ready handshake and no back-pressure. The exposure and geometry inputs are only sampled on the clock edge that accepts a trigger.

Top module: `frame_seq`

## Requirements
- R1: After reset, frame_req_o, sync_o, fval_o, lval_o and done_o are low and overrun_o is zero.
- R2: A trigger that is high at a clock edge while the block is idle is accepted, and frame_req_o is high from the next cycle. exp_cycles_i, rows_i and cols_i are sampled at that same edge, and later changes to them do not affect the frame in progress.
- R3: The frame request stays high for RST_CYC row-reset cycles followed by the exposure cycles. It falls in the same cycle that lval_o first rises. fval_o and lval_o are low while the request is high.
- R4: The exposure phase lasts exp_cycles_i cycles. A value of 0 gives one cycle.
- R5: Readout produces rows_i rows, and lval_o is high for cols_i consecutive cycles in each row. A value of 0 in either input is treated as 1.
- R6: Between consecutive rows lval_o is low for exactly 4 cycles. fval_o is high without a break from the first cycle of the first row to the last cycle of the last row.
- R7: sync_o is a one-cycle pulse that coincides with the first lval_o cycle of every row. It is never high at any other time.
- R8: done_o is high for exactly one cycle, which is the cycle right after the last lval_o cycle. fval_o is low in that cycle.
- R9: A trigger that is high at a clock edge while a frame is in progress, including the done cycle, does not change the sequence. It increments overrun_o by one, and overrun_o saturates at 2^OVR_W-1.
- R10: The cycle after done_o is idle. A trigger seen at the next edge starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Hardware capture trigger, level sampled every edge |
| exp_cycles_i | input | EXP_W | Exposure length in clock cycles (0 means 1) |
| rows_i | input | ROW_W | Rows per frame (0 means 1) |
| cols_i | input | COL_W | Pixels per row, which sets the line-valid width (0 means 1) |
| frame_req_o | output | 1 | Frame request, high during row reset and exposure |
| sync_o | output | 1 | Row pace strobe on the first cycle of each row |
| fval_o | output | 1 | Frame valid across the readout |
| lval_o | output | 1 | Line valid for each row |
| done_o | output | 1 | One-cycle grab-done pulse |
| overrun_o | output | OVR_W | Saturating count of triggers ignored while busy |

## Verification
The bench goes after the degenerate geometry first: zero exposure, zero rows and zero columns. A design that did not clamp these would stall in a phase or wrap a counter into an enormous frame. It also fires triggers in the done cycle and in the cycle just after it. A machine whose idle test was off by one would then either lose the new frame or begin one early. Inputs are changed mid-frame, and the trigger is held high for long enough to saturate the overrun count. These cases expose a design that reads its configuration live, or one whose counter wraps back to zero.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RST  = 3'd1,
    S_EXP  = 3'd2,
    S_LINE = 3'd3,
    S_GAP  = 3'd4,
    S_DONE = 3'd5
  } fs_state_e;
endpackage

// File: rtl/fs_timer.sv
module fs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (ld_i)                 cnt_q <= ld_val_i;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fs_sat_cnt.sv
module fs_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_o <= '0;
    else if (inc_i && cnt_o != MAXV) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
#(
  parameter int EXP_W   = 24,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 12,
  parameter int PH_W    = 24,
  parameter int RST_CYC = 8,
  parameter int GAP_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic             ph_zero_i,
  input  logic             row_zero_i,
  output logic             ph_ld_o,
  output logic [PH_W-1:0]  ph_val_o,
  output logic             row_ld_o,
  output logic [ROW_W-1:0] row_val_o,
  output logic             row_en_o,
  output logic             busy_o,
  output logic             frame_req_o,
  output logic             sync_o,
  output logic             fval_o,
  output logic             lval_o,
  output logic             done_o
);
  fs_state_e  state_q, state_d;
  logic [EXP_W-1:0] exp_q;
  logic [COL_W-1:0] cols_q;
  logic             sync_q, sync_d;
  logic [PH_W-1:0]  exp_m1, cols_m1;

  assign exp_m1  = (exp_q  == '0) ? '0 : PH_W'(exp_q  - 1'b1);
  assign cols_m1 = (cols_q == '0) ? '0 : PH_W'(cols_q - 1'b1);

  always_comb begin
    state_d   = state_q;
    ph_ld_o   = 1'b0;
    ph_val_o  = '0;
    row_ld_o  = 1'b0;
    row_val_o = (rows_i == '0) ? '0 : rows_i - 1'b1;
    row_en_o  = 1'b0;
    sync_d    = 1'b0;
    unique case (state_q)
      S_IDLE: if (trig_i) begin
        state_d  = S_RST;
        ph_ld_o  = 1'b1;
        ph_val_o = PH_W'(RST_CYC - 1);
        row_ld_o = 1'b1;
      end
      S_RST: if (ph_zero_i) begin
        state_d  = S_EXP;
        ph_ld_o  = 1'b1;
        ph_val_o = exp_m1;
      end
      S_EXP: if (ph_zero_i) begin
        state_d  = S_LINE;
        ph_ld_o  = 1'b1;
        ph_val_o = cols_m1;
        sync_d   = 1'b1;
      end
      S_LINE: if (ph_zero_i) begin
        if (row_zero_i) state_d = S_DONE;
        else begin
          state_d  = S_GAP;
          ph_ld_o  = 1'b1;
          ph_val_o = PH_W'(GAP_CYC - 1);
          row_en_o = 1'b1;
        end
      end
      S_GAP: if (ph_zero_i) begin
        state_d  = S_LINE;
        ph_ld_o  = 1'b1;
        ph_val_o = cols_m1;
        sync_d   = 1'b1;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      exp_q   <= '0;
      cols_q  <= '0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_q  <= sync_d;
      if (state_q == S_IDLE && trig_i) begin
        exp_q  <= exp_i;
        cols_q <= cols_i;
      end
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign frame_req_o = (state_q == S_RST) || (state_q == S_EXP);
  assign fval_o      = (state_q == S_LINE) || (state_q == S_GAP);
  assign lval_o      = (state_q == S_LINE);
  assign done_o      = (state_q == S_DONE);
  assign sync_o      = sync_q;

  p_req_after_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && trig_i) |=> frame_req_o);
  p_req_fval_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_req_o && fval_o));
  p_req_to_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_req_o) |-> lval_o);
  p_lval_in_fval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lval_o |-> fval_o);
  p_sync_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lval_o) |-> sync_o);
  p_sync_in_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> lval_o);
  p_fval_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fval_o) |-> done_o);
  p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int EXP_W   = 24,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 12,
  parameter int RST_CYC = 8,
  parameter int GAP_CYC = 4,
  parameter int OVR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [EXP_W-1:0] exp_cycles_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  output logic             frame_req_o,
  output logic             sync_o,
  output logic             fval_o,
  output logic             lval_o,
  output logic             done_o,
  output logic [OVR_W-1:0] overrun_o
);
  localparam int RC_W  = $clog2(RST_CYC + GAP_CYC + 1);
  localparam int W_A   = (EXP_W > COL_W) ? EXP_W : COL_W;
  localparam int PH_W  = (W_A > RC_W) ? W_A : RC_W;
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic             ph_ld, ph_zero, row_ld, row_en, row_zero, busy;
  logic [PH_W-1:0]  ph_val;
  logic [ROW_W-1:0] row_val;

  fs_ctrl #(
    .EXP_W(EXP_W), .ROW_W(ROW_W), .COL_W(COL_W), .PH_W(PH_W),
    .RST_CYC(RST_CYC), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .exp_i(exp_cycles_i), .rows_i(rows_i), .cols_i(cols_i),
    .ph_zero_i(ph_zero), .row_zero_i(row_zero),
    .ph_ld_o(ph_ld), .ph_val_o(ph_val),
    .row_ld_o(row_ld), .row_val_o(row_val), .row_en_o(row_en),
    .busy_o(busy), .frame_req_o(frame_req_o), .sync_o(sync_o),
    .fval_o(fval_o), .lval_o(lval_o), .done_o(done_o)
  );

  fs_timer #(.W(PH_W)) u_phase_tmr (
    .clk(clk), .rst_n(rst_n), .ld_i(ph_ld), .ld_val_i(ph_val),
    .en_i(1'b1), .zero_o(ph_zero)
  );

  fs_timer #(.W(ROW_W)) u_row_tmr (
    .clk(clk), .rst_n(rst_n), .ld_i(row_ld), .ld_val_i(row_val),
    .en_i(row_en), .zero_o(row_zero)
  );

  fs_sat_cnt #(.W(OVR_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .inc_i(busy && trig_i), .cnt_o(overrun_o)
  );

  p_ovr_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_i && overrun_o != OVR_MAX) |=> overrun_o == $past(overrun_o) + 1'b1);
  p_ovr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && trig_i) |=> $stable(overrun_o));
  p_ovr_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o == OVR_MAX) |=> overrun_o == OVR_MAX);
endmodule

// File: tb/frame_seq_tb.sv
module frame_seq_tb_top;
  localparam int RST_CYC = 8;
  localparam int GAP_CYC = 4;
  localparam int OVR_W   = 8;
  localparam int OVR_MAX = 255;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [23:0] exp_c = '0;
  logic [11:0] rows = '0;
  logic [11:0] cols = '0;
  logic        freq, sync, fval, lval, done;
  logic [OVR_W-1:0] ovr;

  frame_seq #(.RST_CYC(RST_CYC), .GAP_CYC(GAP_CYC), .OVR_W(OVR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .exp_cycles_i(exp_c),
    .rows_i(rows), .cols_i(cols), .frame_req_o(freq), .sync_o(sync),
    .fval_o(fval), .lval_o(lval), .done_o(done), .overrun_o(ovr)
  );

  int n_run = 0, n_fail = 0;
  string tag = "R1";

  // model entries: {busy, req, sync, fval, lval, done}
  logic [5:0] mq[$];
  logic [5:0] cur = '0;
  int m_ovr = 0;
  int c_req = 0, c_lval = 0, c_sync = 0, c_done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void build(input int e, input int r, input int c);
    int ee = (e == 0) ? 1 : e;
    int rr = (r == 0) ? 1 : r;
    int cc = (c == 0) ? 1 : c;
    for (int i = 0; i < RST_CYC + ee; i++) mq.push_back(6'b110000);
    for (int y = 0; y < rr; y++) begin
      for (int x = 0; x < cc; x++) mq.push_back((x == 0) ? 6'b101110 : 6'b100110);
      if (y != rr - 1)
        for (int g = 0; g < GAP_CYC; g++) mq.push_back(6'b100100);
    end
    mq.push_back(6'b100001);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      cur = '0;
      m_ovr = 0;
    end else if (cur[5]) begin
      if (trig && m_ovr < OVR_MAX) m_ovr++;
      cur = (mq.size() != 0) ? mq.pop_front() : 6'b0;
    end else if (trig) begin
      build(int'(exp_c), int'(rows), int'(cols));
      cur = mq.pop_front();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({freq, sync, fval, lval, done} == cur[4:0], tag, "strobes",
            int'({freq, sync, fval, lval, done}), int'(cur[4:0]));
      check(int'(ovr) == m_ovr, "R9", "overrun", int'(ovr), m_ovr);
      c_req  += int'(freq);
      c_lval += int'(lval);
      c_sync += int'(sync);
      c_done += int'(done);
    end
  end

  task automatic clr();
    c_req = 0; c_lval = 0; c_sync = 0; c_done = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (cur != 6'b0);
  endtask

  task automatic frame(input int e, input int r, input int c);
    exp_c = 24'(e); rows = 12'(r); cols = 12'(c);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    wait_idle();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int o0;
    repeat (3) @(negedge clk);
    check({freq, sync, fval, lval, done} == 5'b0, "R1", "reset strobes",
          int'({freq, sync, fval, lval, done}), 0);
    check(ovr == '0, "R1", "reset overrun", int'(ovr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // main frame: R2 R3 R5 R6 R7 R8
    tag = "R2/R3/R5/R6/R7/R8"; clr();
    frame(5, 3, 6);
    check(c_req == RST_CYC + 5, "R3", "request cycles", c_req, RST_CYC + 5);
    check(c_lval == 18, "R5", "lval cycles", c_lval, 18);
    check(c_sync == 3, "R7", "sync pulses", c_sync, 3);
    check(c_done == 1, "R8", "done pulses", c_done, 1);

    // zero exposure: R4
    tag = "R4"; clr();
    frame(0, 2, 1);
    check(c_req == RST_CYC + 1, "R4", "zero exposure request cycles", c_req, RST_CYC + 1);
    check(c_lval == 2, "R6", "lval cycles", c_lval, 2);

    // zero geometry: R5
    tag = "R5"; clr();
    frame(2, 0, 0);
    check(c_lval == 1, "R5", "zero geometry lval", c_lval, 1);
    check(c_sync == 1, "R7", "zero geometry sync", c_sync, 1);

    // busy triggers and live input changes: R9 R2
    tag = "R2/R9"; clr();
    o0 = int'(ovr);
    exp_c = 24'd20; rows = 12'd2; cols = 12'd3;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    exp_c = 24'd200; rows = 12'd9; cols = 12'd40;
    repeat (3) @(negedge clk);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    repeat (20) @(negedge clk);
    trig = 1'b1; @(negedge clk); @(negedge clk); trig = 1'b0;
    wait_idle();
    check(c_req == RST_CYC + 20, "R2", "latched exposure", c_req, RST_CYC + 20);
    check(c_lval == 6, "R2", "latched geometry", c_lval, 6);
    check(int'(ovr) == o0 + 3, "R9", "overrun increment", int'(ovr), o0 + 3);

    // trigger across done cycle: R10
    tag = "R10"; clr();
    o0 = int'(ovr);
    exp_c = 24'd1; rows = 12'd1; cols = 12'd2;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    do @(negedge clk); while (!done);
    trig = 1'b1; @(negedge clk); @(negedge clk); trig = 1'b0;
    wait_idle();
    check(c_done == 2, "R10", "frames after done", c_done, 2);
    check(int'(ovr) == o0 + 1, "R10", "done-cycle trigger counted", int'(ovr), o0 + 1);

    // saturation: R9
    tag = "R9";
    exp_c = 24'd600; rows = 12'd1; cols = 12'd1;
    trig = 1'b1;
    repeat (400) @(negedge clk);
    trig = 1'b0;
    wait_idle();
    check(int'(ovr) == OVR_MAX, "R9", "overrun saturation", int'(ovr), OVR_MAX);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule